// File: doc/BRIEF.md
# Battery Pack Protection Controller

This block is the control core of a protector for a pack of lithium cells in series. It decides whether the charge switch and the discharge switch are enabled. It also controls the enable for a small load-test current. It works from three kinds of input. Per-cell overvoltage and undervoltage flags arrive already time-qualified, together with "all cells below charge-enable" and "all cells above undervoltage-release" summaries, from a measurement sequencer on the same clock. Five comparator outputs and a timing-capacitor fault arrive asynchronously. The last input is a static strap that picks how a charger is recognised.

The block has two modes, asleep and awake. It holds a separate latch for each fault: overvoltage, undervoltage, overcurrent and short circuit. Each latch is released only by its own recovery condition. The persistence delays for overcurrent and short circuit are cycle counters inside the block. All asynchronous inputs pass through two-flop synchronizers before any decision. Outputs are registered, so an asynchronous input change reaches the outputs on the third rising edge after it.

Top module: `pack_guard`

## Requirements
- R1: After reset the block is asleep. Whenever it is asleep, the charge, discharge and test-current enables are all low.
- R2: While asleep, the block wakes only if a charger is detected and the load-removed input is high. On a clean wake, both switch enables go high.
- R3: With the strap low, a charger is detected when the charger comparator is high. With the strap high, a charger is detected when the sleep input is high.
- R4: While awake, a low sleep input puts the block to sleep only when no charger is detected.
- R5: A qualified overvoltage turns the charge enable off on the next edge and leaves the discharge enable on. The charge enable returns only once every cell is below the charge-enable threshold.
- R6: A qualified undervoltage with no overcurrent latch turns both enables off and puts the block to sleep. After the next wake, the charge enable is on and the discharge enable stays off until every cell is above the release threshold.
- R7: The discharge enable trips on the overcurrent comparator only after the comparator has been high for DOC_CYC consecutive synchronized cycles. On a continuous assertion this is edge DOC_CYC+2 after the input rises. A shorter pulse resets the count.
- R8: The short-circuit comparator trips the discharge enable the same way, using its own count SC_CYC.
- R9: An overcurrent or short-circuit trip keeps the discharge enable off and the test-current enable on until the load-removed input is seen high, which takes three edges.
- R10: An undervoltage that arrives during a short-circuit latch switches the test current off. An undervoltage that arrives during an overcurrent latch does not put the block to sleep, and the test current stays on.
- R11: While the timing-capacitor fault input is high, both switch enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_qual_i | input | 1 | Qualified overvoltage on some cell (synchronous) |
| uv_qual_i | input | 1 | Qualified undervoltage on some cell (synchronous) |
| all_below_ce_i | input | 1 | Every cell below the charge-enable threshold (synchronous) |
| all_above_rel_i | input | 1 | Every cell above the undervoltage-release threshold (synchronous) |
| doc_cmp_i | input | 1 | Discharge overcurrent comparator (asynchronous) |
| sc_cmp_i | input | 1 | Short-circuit comparator (asynchronous) |
| chg_cmp_i | input | 1 | Charger-attach comparator (asynchronous) |
| load_gone_i | input | 1 | Load-removed comparator (asynchronous) |
| slp_n_i | input | 1 | Sleep input, low requests sleep (asynchronous) |
| strap_i | input | 1 | Charger-detection select strap |
| cap_fault_i | input | 1 | Timing-capacitor fault (asynchronous) |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| tst_en_o | output | 1 | Load-test current enable |
| awake_o | output | 1 | High while awake |

## Verification
The hardest cases to reach are the overlapping faults. An undervoltage has to land while an overcurrent or short-circuit latch is held, and the charger and load-removed inputs must be held low so the block cannot wake straight back up and hide the result. The stimulus first drops the charger and the load-removed inputs. It then holds the comparator long enough to trip and only then pulses the undervoltage flag, before releasing each condition in turn. The detection and sleep logic is swept over every strap, charger and sleep-pin combination, both from the asleep state and from the awake state. The persistence counters are probed one cycle either side of their terminal count.

// File: rtl/pg_pkg.sv
package pg_pkg;
    typedef enum logic {PG_SLEEP = 1'b0, PG_AWAKE = 1'b1} pg_mode_e;

    typedef struct packed {
        pg_mode_e mode;
        logic     ov_lat;
        logic     uv_lat;
        logic     doc_lat;
        logic     sc_lat;
        logic     chg_en;
        logic     dsg_en;
        logic     tst_en;
    } pg_state_t;

    // positions in the synchronizer bundle
    localparam int SY_DOC   = 0;
    localparam int SY_SC    = 1;
    localparam int SY_CHG   = 2;
    localparam int SY_GONE  = 3;
    localparam int SY_SLPN  = 4;
    localparam int SY_STRAP = 5;
    localparam int SY_CAP   = 6;
    localparam int SY_W     = 7;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pg_persist.sv
module pg_persist #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hit_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TERM = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign done_o = en_i && hit_i && (cnt_q == TERM);

    always_comb begin
        if (!en_i || !hit_i)   cnt_d = '0;
        else if (cnt_q < TERM) cnt_d = cnt_q + 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pack_guard.sv
module pack_guard
    import pg_pkg::*;
#(
    parameter int DOC_CYC = 4096,
    parameter int SC_CYC  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ov_qual_i,
    input  logic uv_qual_i,
    input  logic all_below_ce_i,
    input  logic all_above_rel_i,
    input  logic doc_cmp_i,
    input  logic sc_cmp_i,
    input  logic chg_cmp_i,
    input  logic load_gone_i,
    input  logic slp_n_i,
    input  logic strap_i,
    input  logic cap_fault_i,
    output logic chg_en_o,
    output logic dsg_en_o,
    output logic tst_en_o,
    output logic awake_o
);
    logic [SY_W-1:0] raw, syn;
    pg_state_t st_d, st_q;
    logic det, slp_req, doc_done, sc_done, awake_w, doc_lat_w, cap_s, gone_s;

    assign raw = {cap_fault_i, strap_i, slp_n_i, load_gone_i,
                  chg_cmp_i, sc_cmp_i, doc_cmp_i};

    pg_sync #(.W(SY_W), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(syn)
    );

    assign awake_w   = (st_q.mode == PG_AWAKE);
    assign doc_lat_w = st_q.doc_lat;
    assign cap_s     = syn[SY_CAP];
    assign gone_s    = syn[SY_GONE];
    assign det       = syn[SY_STRAP] ? syn[SY_SLPN] : syn[SY_CHG];
    assign slp_req   = !syn[SY_SLPN] && !det;

    pg_persist #(.LIMIT(DOC_CYC)) u_doc_tmr (
        .clk(clk), .rst_n(rst_n), .en_i(awake_w),
        .hit_i(syn[SY_DOC]), .done_o(doc_done)
    );

    pg_persist #(.LIMIT(SC_CYC)) u_sc_tmr (
        .clk(clk), .rst_n(rst_n), .en_i(awake_w),
        .hit_i(syn[SY_SC]), .done_o(sc_done)
    );

    always_comb begin
        logic aw;
        st_d = st_q;
        if (st_q.mode == PG_SLEEP) begin
            if (det && gone_s) begin
                st_d.mode    = PG_AWAKE;
                st_d.doc_lat = 1'b0;
                st_d.sc_lat  = 1'b0;
            end
        end else begin
            if (ov_qual_i)           st_d.ov_lat = 1'b1;
            else if (all_below_ce_i) st_d.ov_lat = 1'b0;

            if (uv_qual_i)            st_d.uv_lat = 1'b1;
            else if (all_above_rel_i) st_d.uv_lat = 1'b0;

            if (doc_done)    st_d.doc_lat = 1'b1;
            else if (gone_s) st_d.doc_lat = 1'b0;

            if (sc_done)     st_d.sc_lat = 1'b1;
            else if (gone_s) st_d.sc_lat = 1'b0;

            if (uv_qual_i && !st_d.doc_lat) st_d.mode = PG_SLEEP;
            else if (slp_req)               st_d.mode = PG_SLEEP;
        end

        aw = (st_d.mode == PG_AWAKE);
        st_d.chg_en = aw && !st_d.ov_lat && !(st_d.uv_lat && !det) && !cap_s;
        st_d.dsg_en = aw && !st_d.uv_lat && !st_d.doc_lat && !st_d.sc_lat && !cap_s;
        st_d.tst_en = aw && (st_d.doc_lat || (st_d.sc_lat && !st_d.uv_lat));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: PG_SLEEP, default: 1'b0};
        else        st_q <= st_d;
    end

    assign chg_en_o = st_q.chg_en;
    assign dsg_en_o = st_q.dsg_en;
    assign tst_en_o = st_q.tst_en;
    assign awake_o  = awake_w;
endmodule

// File: rtl/pg_check.sv
module pg_check (
    input logic clk,
    input logic rst_n,
    input logic ov_qual_i,
    input logic uv_qual_i,
    input logic awake_o,
    input logic chg_en_o,
    input logic dsg_en_o,
    input logic tst_en_o,
    input logic doc_lat,
    input logic doc_done,
    input logic slp_req,
    input logic cap_s
);
    p_sleep_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !awake_o |-> (!chg_en_o && !dsg_en_o && !tst_en_o));

    p_ov_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_o && ov_qual_i) |=> !chg_en_o);

    p_uv_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_o && uv_qual_i && !doc_lat && !doc_done) |=> (!awake_o && !dsg_en_o));

    p_doc_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        doc_done |=> !dsg_en_o);

    p_tst_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tst_en_o |-> !dsg_en_o);

    p_doc_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (awake_o && doc_lat && !slp_req) |=> awake_o);

    p_cap_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cap_s |=> (!chg_en_o && !dsg_en_o));
endmodule

bind pack_guard pg_check u_pg_check (
    .clk(clk), .rst_n(rst_n), .ov_qual_i(ov_qual_i), .uv_qual_i(uv_qual_i),
    .awake_o(awake_o), .chg_en_o(chg_en_o), .dsg_en_o(dsg_en_o),
    .tst_en_o(tst_en_o), .doc_lat(doc_lat_w), .doc_done(doc_done),
    .slp_req(slp_req), .cap_s(cap_s)
);

// File: tb/tb_pack_guard.sv
module tb_pack_guard;
    localparam int CLK_PERIOD = 10;
    localparam int DOC = 12;
    localparam int SC  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov = 0, uv = 0, below_ce = 1, above_rel = 1;
    logic doc = 0, sc = 0, chg = 0, gone = 1, sn = 1, strap = 0, cap = 0;
    logic chg_en, dsg_en, tst_en, awake;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pack_guard #(.DOC_CYC(DOC), .SC_CYC(SC)) dut (
        .clk(clk), .rst_n(rst_n), .ov_qual_i(ov), .uv_qual_i(uv),
        .all_below_ce_i(below_ce), .all_above_rel_i(above_rel),
        .doc_cmp_i(doc), .sc_cmp_i(sc), .chg_cmp_i(chg), .load_gone_i(gone),
        .slp_n_i(sn), .strap_i(strap), .cap_fault_i(cap),
        .chg_en_o(chg_en), .dsg_en_o(dsg_en), .tst_en_o(tst_en), .awake_o(awake)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(4);
        // R1: reset state is asleep and dark
        chk("R1 awake", awake, 1'b0);
        chk("R1 chg", chg_en, 1'b0);
        chk("R1 dsg", dsg_en, 1'b0);
        chk("R1 tst", tst_en, 1'b0);

        // R2/R3: wake sweep from sleep
        for (int st = 0; st < 2; st++)
            for (int cg = 0; cg < 2; cg++)
                for (int s = 0; s < 2; s++) begin
                    logic e;
                    strap = 0; chg = 0; sn = 0; step(5);
                    strap = st[0]; chg = cg[0]; sn = s[0]; step(5);
                    e = st[0] ? s[0] : cg[0];
                    chk("R3 wake detect", awake, e);
                    chk("R2 wake chg", chg_en, e);
                    chk("R2 wake dsg", dsg_en, e);
                end
        // R2: no wake without load removed
        strap = 0; chg = 0; sn = 0; step(5);
        gone = 0; chg = 1; sn = 1; step(6);
        chk("R2 blocked by load", awake, 1'b0);
        gone = 1; step(3);
        chk("R2 wake after load", awake, 1'b1);

        // R4: sleep-request sweep from awake
        for (int st = 0; st < 2; st++)
            for (int cg = 0; cg < 2; cg++)
                for (int s = 0; s < 2; s++) begin
                    logic dt;
                    strap = 0; chg = 1; sn = 1; step(5);
                    strap = st[0]; chg = cg[0]; sn = s[0]; step(5);
                    dt = st[0] ? s[0] : cg[0];
                    chk("R4 sleep request", awake, !(!s[0] && !dt));
                end
        strap = 0; chg = 1; sn = 1; step(5);

        // R5: overvoltage
        ov = 1; below_ce = 0; step(1);
        ov = 0;
        chk("R5 chg off", chg_en, 1'b0);
        chk("R5 dsg kept", dsg_en, 1'b1);
        step(4);
        chk("R5 held until ce", chg_en, 1'b0);
        below_ce = 1; step(1);
        chk("R5 released", chg_en, 1'b1);

        // R6: undervoltage
        chg = 0; step(4);
        above_rel = 0; uv = 1; step(1);
        uv = 0;
        chk("R6 sleep", awake, 1'b0);
        chk("R6 dsg off", dsg_en, 1'b0);
        chk("R6 chg off", chg_en, 1'b0);
        chg = 1; step(3);
        chk("R6 wake", awake, 1'b1);
        chk("R6 chg on", chg_en, 1'b1);
        chk("R6 dsg held", dsg_en, 1'b0);
        step(4);
        chk("R6 dsg still held", dsg_en, 1'b0);
        above_rel = 1; step(1);
        chk("R6 dsg released", dsg_en, 1'b1);

        // R7: overcurrent persistence
        gone = 0; step(4);
        doc = 1; step(DOC - 1);
        doc = 0; step(5);
        chk("R7 short pulse", dsg_en, 1'b1);
        doc = 1; step(DOC + 1);
        chk("R7 before count", dsg_en, 1'b1);
        step(1);
        chk("R7 trip", dsg_en, 1'b0);
        chk("R9 tst on doc", tst_en, 1'b1);
        doc = 0; step(5);
        chk("R9 doc held", dsg_en, 1'b0);
        gone = 1; step(2);
        chk("R9 doc pre-release", dsg_en, 1'b0);
        step(1);
        chk("R9 doc released", dsg_en, 1'b1);
        chk("R9 tst off", tst_en, 1'b0);

        // R8: short-circuit persistence
        gone = 0; step(4);
        sc = 1; step(SC + 1);
        chk("R8 before count", dsg_en, 1'b1);
        step(1);
        chk("R8 trip", dsg_en, 1'b0);
        chk("R9 tst on sc", tst_en, 1'b1);
        sc = 0;

        // R10: undervoltage during short-circuit latch
        chg = 0; step(4);
        above_rel = 0; uv = 1; step(1);
        uv = 0;
        chk("R10 sc uv sleep", awake, 1'b0);
        chk("R10 sc uv tst off", tst_en, 1'b0);
        above_rel = 1; chg = 1; gone = 1; step(5);
        chk("R9 sc release via wake", dsg_en, 1'b1);

        // R10: undervoltage during overcurrent latch
        chg = 0; gone = 0; step(4);
        doc = 1; step(DOC + 3);
        above_rel = 0; uv = 1; step(1);
        uv = 0;
        chk("R10 doc uv awake", awake, 1'b1);
        chk("R10 doc uv tst", tst_en, 1'b1);
        chk("R10 doc uv dsg", dsg_en, 1'b0);
        chk("R10 doc uv chg", chg_en, 1'b0);
        step(3);
        chk("R10 doc uv still awake", awake, 1'b1);
        doc = 0; gone = 1; above_rel = 1; step(4);
        chk("R10 recovered", dsg_en, 1'b1);

        // R11: capacitor fault
        cap = 1; step(3);
        chk("R11 chg off", chg_en, 1'b0);
        chk("R11 dsg off", dsg_en, 1'b0);
        cap = 0; step(3);
        chk("R11 chg back", chg_en, 1'b1);
        chk("R11 dsg back", dsg_en, 1'b1);

        finish_run();
    end
endmodule